// File: doc/BRIEF.md
# Register-Triggered Two-Wire Byte/Word Master

This block is a host-programmed two-wire (SMBus/I2C style) master for memory-module sideband devices such as serial-presence EEPROMs and temperature sensors. Software first loads a 32-bit control word. That word carries the upper address nibble, a clock-enable bit, a write lock and a background-poll enable. Software then writes a 32-bit command word with its launch bit set. Each launch runs exactly one byte or word read or write on the wire. Software then watches the status outputs: busy, write-done, read-valid, bus-error and read data.

A write puts these on the wire in turn: start, address with R/W low, command byte, then one or two data bytes, then stop. A read sends the address with R/W low and the command byte. It then issues a repeated start and the address with R/W high, and clocks in one or two bytes. The master acknowledges every received byte except the last, which it NACKs, and then sends a stop. Words use I2C order on the wire: the most significant byte goes first. SCL and SDA are open-drain. Each is driven as an output-enable that pulls the line low, and SDA is read back through an input. The background poller is not part of this block. The block only produces its permission signal and sees its in-flight flag.

The sequencer has seven states. ST_IDLE waits for a launch (idle→START on launch). ST_START makes a start or repeated start (START→TXBIT). ST_TXBIT shifts out eight bits (TXBIT→TXACK). ST_TXACK samples the target's acknowledge. From there it moves to STOP on a NACK or after the last write byte, back to START after the command byte of a read, to RXBIT after the read address, and otherwise to TXBIT for the next byte. ST_RXBIT shifts in eight bits (RXBIT→RXACK). ST_RXACK drives ACK or NACK (RXACK→RXBIT when another byte follows, else RXACK→STOP). ST_STOP makes the stop condition and returns to idle (STOP→IDLE). Each bit lasts four phases of a divided clock tick. SCL is low in phases 0–1 and released in phases 2–3. SDA holds its previous level in phase 0.

Top module: `smbus_host`

## Requirements
- R1: A command write with bit 31 set launches a transaction only if the block is idle and control bit 27 (clock enable) is set; busy is high at the first sample after that clock edge. A command write with bit 31 clear launches nothing.
- R2: The 7-bit target address is control bits [31:28] followed by command bits [26:24]; the first byte on the wire is that address shifted left with R/W = 0.
- R3: Command bit 27 set selects a write: the wire carries address+W, command bits [23:16], then data. A byte write (command bit 29 clear) sends bits [7:0] and ignores [15:8]; a word write sends [15:8] first and then [7:0].
- R4: Command bit 27 clear selects a read: address+W, command byte, repeated start, address+R, then one byte (bit 29 clear) or two bytes (bit 29 set). The master ACKs every byte except the last, which it NACKs. Read data shows as {8'h00, byte} for a byte read and {first, second} for a word read.
- R5: Busy stays high from the launch until the stop condition completes. When the block is idle, both line enables are released.
- R6: Write-done is set when a write finishes and is cleared only when a write launches. Read-valid is set when a read finishes and is cleared only when a read launches, so a write leaves read-valid as it was.
- R7: If a byte is not acknowledged, the master raises bus-error, sends a stop at once, drops busy, and still sets the completion flag for that transaction type. Every launch clears bus-error.
- R8: A command write that arrives while busy is high has no effect.
- R9: A write launch is ignored while control bit 26 (write lock) is set. Every launch is ignored while control bit 27 is clear.
- R10: SDA changes only while SCL is low, except for the start, repeated-start and stop conditions. Each transaction therefore shows exactly one start, one extra start per read, and one stop.
- R11: The poll-permit output equals control bit 9 while no transfer runs. While the poll-in-flight input is high, busy is high and triggers are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Load the control word |
| ctrl_wdata | input | 32 | Control word: [31:28] address high nibble, [27] clock enable, [26] write lock, [9] poll enable |
| cmd_wr | input | 1 | Write the command word |
| cmd_wdata | input | 32 | Command word: [31] launch, [29] word, [27] write, [26:24] address low bits, [23:16] command byte, [15:0] write data |
| poll_inflight | input | 1 | Background poll currently on the bus |
| sda_in | input | 1 | Level sensed on the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transaction or poll in progress |
| wr_done | output | 1 | Sticky write-complete flag |
| rd_valid | output | 1 | Sticky read-complete flag |
| bus_err | output | 1 | Last transaction saw a missing acknowledge |
| rd_data | output | 16 | Data from the last successful read |
| poll_permit | output | 1 | Background polling may run |

## Verification
The assertions assume that the SDA input follows the wire-AND of the master's enable and a target that changes SDA only while SCL is low. They also assume that control and command writes never fall in the same cycle. The sticky-flag properties further assume that the only way to start a transaction is a command write. The bench keeps to these conditions. Its target model reacts on the falling clock edge, only after it has seen SCL go low. Every register write is a separate one-cycle pulse, and the control word is loaded before each launch. Missing acknowledges are injected only on bytes that the master sends.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_TXBIT,
        ST_TXACK,
        ST_RXBIT,
        ST_RXACK,
        ST_STOP
    } seq_state_e;

    typedef struct packed {
        logic        rd;
        logic        word;
        logic [6:0]  addr;
        logic [7:0]  cmd;
        logic [15:0] wdata;
    } xfer_req_t;

    localparam int CMD_GO     = 31;
    localparam int CMD_WORD   = 29;
    localparam int CMD_WRITE  = 27;
    localparam int CTL_CLKOK  = 27;
    localparam int CTL_WRLOCK = 26;
    localparam int CTL_POLL   = 9;
endpackage

// File: rtl/smbh_tick.sv
module smbh_tick #(
    parameter int QDIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
#(
    parameter int QDIV = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  xfer_req_t   req_i,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        seq_busy,
    output logic        seq_done,
    output logic        seq_nack,
    output logic [15:0] seq_rdata
);
    seq_state_e st, st_nx;
    xfer_req_t  req;
    logic [1:0] ph, bidx;
    logic [2:0] bcnt;
    logic [6:0] rsh;
    logic       ridx, nack, sda_q, sda_drv, tick, last_ph, more;
    logic [1:0] last_tx;
    logic [7:0] txbyte;

    smbh_tick #(.QDIV(QDIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st != ST_IDLE),
        .tick (tick)
    );

    assign last_ph = tick && (ph == 2'd3);
    assign more    = req.word && !ridx;
    assign last_tx = req.word ? 2'd3 : 2'd2;

    always_comb begin
        unique case (bidx)
            2'd0:    txbyte = {req.addr, 1'b0};
            2'd1:    txbyte = req.cmd;
            2'd2:    txbyte = req.rd ? {req.addr, 1'b1}
                                     : (req.word ? req.wdata[15:8] : req.wdata[7:0]);
            default: txbyte = req.wdata[7:0];
        endcase
    end

    // next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (go) st_nx = ST_START;
            ST_START: if (last_ph) st_nx = ST_TXBIT;
            ST_TXBIT: if (last_ph && bcnt == 3'd7) st_nx = ST_TXACK;
            ST_TXACK: if (last_ph) begin
                if (sda_in)                          st_nx = ST_STOP;
                else if (!req.rd && bidx == last_tx) st_nx = ST_STOP;
                else if (req.rd && bidx == 2'd1)     st_nx = ST_START;
                else if (req.rd && bidx == 2'd2)     st_nx = ST_RXBIT;
                else                                 st_nx = ST_TXBIT;
            end
            ST_RXBIT: if (last_ph && bcnt == 3'd7) st_nx = ST_RXACK;
            ST_RXACK: if (last_ph) st_nx = more ? ST_RXBIT : ST_STOP;
            ST_STOP:  if (last_ph) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE; req <= '0; ph <= '0; bidx <= '0; bcnt <= '0;
            rsh <= '0; ridx <= 1'b0; nack <= 1'b0; sda_q <= 1'b0; seq_rdata <= '0;
        end else begin
            st    <= st_nx;
            sda_q <= sda_oe;
            if (st == ST_IDLE) begin
                if (go) begin
                    req <= req_i; ph <= '0; bidx <= '0; bcnt <= '0;
                    ridx <= 1'b0; nack <= 1'b0;
                end
            end else if (tick) begin
                ph <= ph + 2'd1;
                if (ph == 2'd3) begin
                    if (st == ST_TXBIT) bcnt <= bcnt + 3'd1;
                    if (st == ST_RXBIT) begin
                        bcnt <= bcnt + 3'd1;
                        rsh  <= {rsh[5:0], sda_in};
                        if (bcnt == 3'd7)
                            seq_rdata <= req.word ? {seq_rdata[7:0], rsh, sda_in}
                                                  : {8'h00, rsh, sda_in};
                    end
                    if (st == ST_TXACK) begin
                        if (sda_in) nack <= 1'b1;
                        else if (st_nx == ST_START) bidx <= 2'd2;
                        else if (st_nx == ST_TXBIT) bidx <= bidx + 2'd1;
                    end
                    if (st == ST_RXACK && more) ridx <= 1'b1;
                end
            end
        end
    end

    // line outputs
    always_comb begin
        sda_drv = 1'b0;
        unique case (st)
            ST_IDLE:           sda_drv = 1'b0;
            ST_START:          sda_drv = (ph == 2'd3);
            ST_TXBIT:          sda_drv = !txbyte[3'd7 - bcnt];
            ST_TXACK, ST_RXBIT: sda_drv = 1'b0;
            ST_RXACK:          sda_drv = more;
            ST_STOP:           sda_drv = (ph != 2'd3);
            default:           sda_drv = 1'b0;
        endcase
        scl_oe   = (st != ST_IDLE) && !ph[1];
        sda_oe   = (st != ST_IDLE && ph == 2'd0) ? sda_q : sda_drv;
        seq_busy = (st != ST_IDLE);
        seq_done = (st == ST_STOP) && last_ph;
        seq_nack = nack;
    end

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_START && st != ST_STOP && sda_oe != $past(sda_oe))
        |-> (scl_oe && $past(scl_oe))); // R10
endmodule

// File: rtl/smbus_host.sv
module smbus_host
    import smbh_pkg::*;
#(
    parameter int QDIV = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_wdata,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    input  logic        poll_inflight,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        busy,
    output logic        wr_done,
    output logic        rd_valid,
    output logic        bus_err,
    output logic [15:0] rd_data,
    output logic        poll_permit
);
    logic [3:0] addr_hi;
    logic       clk_ok, wr_lock, poll_en, cur_rd;
    logic       launch, is_wr, seq_busy, seq_done, seq_nack;
    logic [15:0] seq_rdata;
    xfer_req_t  req;
    logic       in_unused;

    assign in_unused = ^{ctrl_wdata[25:10], ctrl_wdata[8:0], cmd_wdata[30], cmd_wdata[28]};

    assign is_wr  = cmd_wdata[CMD_WRITE];
    assign busy   = seq_busy || poll_inflight;
    assign launch = cmd_wr && cmd_wdata[CMD_GO] && !busy && clk_ok && !(is_wr && wr_lock);
    assign poll_permit = poll_en && !seq_busy;

    always_comb begin
        req.rd    = !is_wr;
        req.word  = cmd_wdata[CMD_WORD];
        req.addr  = {addr_hi, cmd_wdata[26:24]};
        req.cmd   = cmd_wdata[23:16];
        req.wdata = cmd_wdata[15:0];
    end

    smbh_seq #(.QDIV(QDIV)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (launch),
        .req_i    (req),
        .sda_in   (sda_in),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .seq_busy (seq_busy),
        .seq_done (seq_done),
        .seq_nack (seq_nack),
        .seq_rdata(seq_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hi <= '0; clk_ok <= 1'b0; wr_lock <= 1'b0; poll_en <= 1'b0;
            wr_done <= 1'b0; rd_valid <= 1'b0; bus_err <= 1'b0;
            rd_data <= '0; cur_rd <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                addr_hi <= ctrl_wdata[31:28];
                clk_ok  <= ctrl_wdata[CTL_CLKOK];
                wr_lock <= ctrl_wdata[CTL_WRLOCK];
                poll_en <= ctrl_wdata[CTL_POLL];
            end
            if (launch) begin
                if (is_wr) wr_done <= 1'b0;
                else       rd_valid <= 1'b0;
                bus_err <= 1'b0;
                cur_rd  <= !is_wr;
            end else if (seq_done) begin
                if (cur_rd) begin
                    rd_valid <= 1'b1;
                    if (!seq_nack) rd_data <= seq_rdata;
                end else begin
                    wr_done <= 1'b1;
                end
                bus_err <= seq_nack;
            end
        end
    end

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy); // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_busy); // R5
    AST_RDV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !(launch && !is_wr)) |=> rd_valid); // R6
    AST_WRD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !(launch && is_wr)) |=> wr_done); // R6
    AST_ERR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> (wr_done || rd_valid)); // R7
endmodule

// File: tb/smbus_host_test.sv
module smbus_host_test;
    localparam int QDIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        ctrl_wr = 1'b0, cmd_wr = 1'b0, poll_inflight = 1'b0;
    logic [31:0] ctrl_wdata = '0, cmd_wdata = '0;
    logic        scl_oe, sda_oe, busy, wr_done, rd_valid, bus_err, poll_permit;
    logic [15:0] rd_data;
    logic        s_oe = 1'b0;
    logic        sda_line;

    assign sda_line = !(sda_oe || s_oe);

    smbus_host #(.QDIV(QDIV)) uut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .poll_inflight(poll_inflight), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .wr_done(wr_done), .rd_valid(rd_valid), .bus_err(bus_err),
        .rd_data(rd_data), .poll_permit(poll_permit)
    );

    // target model
    int nb, nstart, nstop, bc, rcount, nack_at;
    logic first, reading, acked, pscl, psda, sc, sd;
    logic [7:0] sh;
    logic [7:0] logb [8];
    logic [7:0] sbytes [2];
    logic [1:0] mack;

    initial begin
        nb = 0; nstart = 0; nstop = 0; bc = 0; rcount = 0; nack_at = 7;
        first = 0; reading = 0; acked = 0; pscl = 1; psda = 1; sh = 0; mack = 0;
    end

    always @(negedge clk) begin
        sc = !scl_oe;
        sd = !(sda_oe || s_oe);
        if (rst_n) begin
            if (pscl && sc && psda && !sd) begin
                nstart++; bc = 0; first = 1;
            end else if (pscl && sc && !psda && sd) begin
                nstop++;
            end else if (!pscl && sc) begin
                if (bc < 8) sh = {sh[6:0], sd};
                else if (reading) mack[rcount] = sd;
                bc++;
            end else if (pscl && !sc) begin
                if (bc == 8) begin
                    if (nb < 8) logb[nb] = sh;
                    if (reading) s_oe = 1'b0;
                    else begin acked = (nb != nack_at); s_oe = acked; end
                    nb++;
                end else if (bc == 9) begin
                    bc = 0;
                    if (reading) begin
                        if (mack[rcount] == 1'b0 && rcount < 1) begin
                            rcount++; s_oe = !sbytes[rcount][7];
                        end else begin
                            reading = 0; s_oe = 1'b0;
                        end
                    end else begin
                        s_oe = 1'b0;
                        if (first && sh[0] && acked) begin
                            reading = 1; s_oe = !sbytes[rcount][7];
                        end
                    end
                    first = 0;
                end else if (reading && bc >= 1 && bc <= 7) begin
                    s_oe = !sbytes[rcount][7-bc];
                end
            end
        end
        pscl = sc;
        psda = sd;
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_cmd(input logic [31:0] v);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic clr_target(input int na);
        @(posedge clk);
        nb = 0; nstart = 0; nstop = 0; rcount = 0; mack = 2'b00; nack_at = na;
    endtask

    task automatic wait_idle(input string rq);
        int k = 0;
        while (busy && k < 5000) begin @(negedge clk); k++; end
        chk({rq, " transfer ends"}, int'(k < 5000), 1);
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [3:0] ahi, input logic ok,
                                            input logic lock, input logic poll);
        mk_ctrl = {ahi, ok, lock, 16'h0, poll, 9'h0};
    endfunction

    function automatic logic [31:0] mk_cmd(input logic go, input logic wd, input logic wr,
                                           input logic [2:0] alo, input logic [7:0] c,
                                           input logic [15:0] d);
        mk_cmd = {go, 1'b0, wd, 1'b0, wr, alo, c, d};
    endfunction

    // [35] write, [34] word, [33:30] addr hi, [29:27] addr lo, [26:19] command,
    // [18:3] data (write data or target read data), [2:0] byte index to NACK (7 = none)
    localparam logic [35:0] VEC [6] = '{
        {1'b0, 1'b0, 4'hA, 3'd0, 8'h24, 16'h00C3, 3'd7},
        {1'b1, 1'b0, 4'h5, 3'd2, 8'h07, 16'hEE5A, 3'd7},
        {1'b0, 1'b1, 4'h3, 3'd1, 8'h05, 16'hB61E, 3'd7},
        {1'b1, 1'b1, 4'h3, 3'd1, 8'h01, 16'h9C42, 3'd7},
        {1'b1, 1'b0, 4'h6, 3'd3, 8'h11, 16'h0033, 3'd0},
        {1'b0, 1'b1, 4'h5, 3'd7, 8'h40, 16'h1234, 3'd2}
    };

    logic exp_wd = 1'b0, exp_rv = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        sbytes[0] = 8'h00; sbytes[1] = 8'h00;
        repeat (3) @(negedge clk);
        // reset state
        chk("R5 reset busy", int'(busy), 0);
        chk("R5 reset lines", int'({scl_oe, sda_oe}), 0);
        chk("R6 reset flags", int'({wr_done, rd_valid, bus_err}), 0);
        chk("R11 reset permit", int'(poll_permit), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            logic        w, wd;
            logic [6:0]  a7;
            logic [7:0]  c;
            logic [15:0] d;
            int          na, enb, est;
            logic [7:0]  eb [5];
            w = VEC[i][35]; wd = VEC[i][34]; a7 = VEC[i][33:27];
            c = VEC[i][26:19]; d = VEC[i][18:3]; na = int'(VEC[i][2:0]);
            sbytes[0] = wd ? d[15:8] : d[7:0];
            sbytes[1] = d[7:0];
            eb[0] = {a7, 1'b0}; eb[1] = c;
            if (w) begin
                eb[2] = wd ? d[15:8] : d[7:0]; eb[3] = d[7:0]; eb[4] = 8'h00;
                enb = wd ? 4 : 3; est = 1;
            end else begin
                eb[2] = {a7, 1'b1}; eb[3] = sbytes[0]; eb[4] = sbytes[1];
                enb = wd ? 5 : 4; est = 2;
            end
            if (na != 7) begin enb = na + 1; if (na < 2) est = 1; end
            clr_target(na);
            wr_ctrl(mk_ctrl(a7[6:3], 1'b1, 1'b0, 1'b0));
            wr_cmd(mk_cmd(1'b1, wd, w, a7[2:0], c, d));
            if (w) exp_wd = 1'b0; else exp_rv = 1'b0;
            chk("R1 busy after launch", int'(busy), 1);
            chk("R6 flags at launch", int'({wr_done, rd_valid}), int'({exp_wd, exp_rv}));
            wait_idle("R5");
            if (w) exp_wd = 1'b1; else exp_rv = 1'b1;
            chk("R5 lines released", int'({scl_oe, sda_oe}), 0);
            chk("R6 flags at end", int'({wr_done, rd_valid}), int'({exp_wd, exp_rv}));
            chk("R7 bus error", int'(bus_err), int'(na != 7));
            chk("R10 start count", nstart, est);
            chk("R10 stop count", nstop, 1);
            chk(w ? "R3 byte count" : "R4 byte count", nb, enb);
            chk("R2 address byte", int'(logb[0]), int'(eb[0]));
            for (int k = 1; k < 5; k++)
                if (k < enb && k < nb)
                    chk(w ? "R3 wire byte" : "R4 wire byte", int'(logb[k]), int'(eb[k]));
            if (!w && na == 7) begin
                chk("R4 read data", int'(rd_data), int'(wd ? d : {8'h00, d[7:0]}));
                chk("R4 master ack/nack", int'(wd ? mack : {1'b0, mack[0]}),
                    int'(wd ? 2'b10 : 2'b01));
            end
            repeat (3) @(negedge clk);
        end

        // R8: second trigger during a running write
        clr_target(7);
        wr_ctrl(mk_ctrl(4'h2, 1'b1, 1'b0, 1'b0));
        wr_cmd(mk_cmd(1'b1, 1'b0, 1'b1, 3'd4, 8'h33, 16'h0077));
        repeat (20) @(negedge clk);
        wr_cmd(mk_cmd(1'b1, 1'b1, 1'b0, 3'd1, 8'h44, 16'h0000));
        wait_idle("R8");
        repeat (60) @(negedge clk);
        chk("R8 busy trigger ignored busy", int'(busy), 0);
        chk("R8 busy trigger ignored starts", nstart, 1);
        chk("R8 busy trigger ignored bytes", nb, 3);
        chk("R8 original payload", int'(logb[2]), 8'h77);

        // R9: write lock and clock enable
        clr_target(7);
        wr_ctrl(mk_ctrl(4'h2, 1'b1, 1'b1, 1'b0));
        wr_cmd(mk_cmd(1'b1, 1'b0, 1'b1, 3'd0, 8'h01, 16'h0001));
        chk("R9 locked write busy", int'(busy), 0);
        wr_ctrl(mk_ctrl(4'h2, 1'b0, 1'b0, 1'b0));
        wr_cmd(mk_cmd(1'b1, 1'b0, 1'b0, 3'd0, 8'h01, 16'h0000));
        chk("R9 clock-off read busy", int'(busy), 0);
        // R1: launch bit clear
        wr_ctrl(mk_ctrl(4'h2, 1'b1, 1'b0, 1'b0));
        wr_cmd(mk_cmd(1'b0, 1'b0, 1'b0, 3'd0, 8'h01, 16'h0000));
        chk("R1 no launch bit busy", int'(busy), 0);
        repeat (40) @(negedge clk);
        chk("R9 R1 no start seen", nstart, 0);

        // R11: poll permit and in-flight poll
        wr_ctrl(mk_ctrl(4'h2, 1'b1, 1'b0, 1'b1));
        chk("R11 permit when idle", int'(poll_permit), 1);
        @(negedge clk); poll_inflight = 1'b1;
        @(negedge clk);
        chk("R11 busy during poll", int'(busy), 1);
        wr_cmd(mk_cmd(1'b1, 1'b0, 1'b0, 3'd0, 8'h02, 16'h0000));
        @(negedge clk); poll_inflight = 1'b0;
        @(negedge clk);
        chk("R11 busy after poll", int'(busy), 0);
        repeat (40) @(negedge clk);
        chk("R11 trigger refused during poll", nstart, 0);
        clr_target(7);
        wr_cmd(mk_cmd(1'b1, 1'b0, 1'b0, 3'd0, 8'h02, 16'h0000));
        repeat (5) @(negedge clk);
        chk("R11 permit withheld in transfer", int'(poll_permit), 0);
        wait_idle("R11");
        chk("R11 permit restored", int'(poll_permit), 1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule